// File: doc/BRIEF.md
# Single-Adder Carry-Select Group

This block is one group of a carry-select adder chain. Only one ripple-carry adder is built, with its carry-in fixed at zero. The carry-in-one result is not computed by a second adder. It is derived from the zero-assumed sum by detecting the lowest zero bit. The bits from the least significant position up to and including that first zero are inverted, and all higher bits pass unchanged. The group carry-in picks the zero-assumed result or its incremented form, and does so bit by bit.

The select for bit i is the group carry-in ANDed with a running all-ones prefix of the lower zero-assumed sum bits. Every bit has its own select mux, and that includes the top bit. The carry-out is the ripple carry-out when the carry-in is 0. When the carry-in is 1, the carry-out is the ripple carry-out ORed with the flag that the zero-assumed sum is all ones.

To suit an FPGA-style pipeline, the sum and carry-out are registered once, with a synchronous active-high reset. The width is a parameter from 1 to 16.

Top module: `addone_csel_group`

## Requirements
- R1: While `rst` is 1 at a rising edge of `clk`, `sum_o` and `cout_o` become 0 after that edge.
- R2: For every input sampled at a rising edge outside reset, the next edge presents `{cout_o, sum_o}` equal to `a_i + b_i + cin_i` as a (WIDTH+1)-bit value. The carry-out is bit WIDTH.
- R3: With `cin_i` = 0, `sum_o` equals the low WIDTH bits of `a_i + b_i`. `cout_o` equals the carry out of that addition.
- R4: With `cin_i` = 1 and S0 = (`a_i` + `b_i`) mod 2^WIDTH not all ones, the bits of S0 from bit 0 up to and including its lowest 0 bit appear inverted in `sum_o`. Higher bits appear unchanged, and `cout_o` equals the carry of `a_i` + `b_i`.
- R5: With `cin_i` = 1 and S0 all ones, `sum_o` is all zeros and `cout_o` is 1.
- R6: With `cin_i` = 0 and S0 all ones, `sum_o` is all ones and `cout_o` is 0.
- R7: With `cin_i` = 1 and S0 having its lower WIDTH-1 bits at 1 and its top bit at 0, the top bit of `sum_o` is inverted to 1 and all lower bits are 0. The top bit has its own select.
- R8: The same behaviour holds for WIDTH = 1, where the only bit still passes through its select mux, and for WIDTH = 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Group carry-in |
| sum_o | output | WIDTH | Registered group sum |
| cout_o | output | 1 | Registered group carry-out |

## Verification
The hardest cases to reach are the ones where the zero-assumed sum is all ones or nearly all ones. Random operands make the prefix chain run the full width only about once in 2^WIDTH vectors, so random stimulus alone rarely reaches them. The bench covers a 6-bit instance exhaustively, which visits every first-zero position with both carry-in values. It also drives directed operand pairs whose sum is all ones, or all ones below a clear top bit, on the 1-bit and 16-bit instances. Random vectors on the 16-bit instance cover the general case.

// File: rtl/addsel_pkg.sv
package addsel_pkg;
  localparam int MAX_WIDTH = 16;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x ^ y));
  endfunction
endpackage

// File: rtl/rca_cin0.sv
module rca_cin0 #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] s0,
  output logic             cout0
);
  import addsel_pkg::*;

  logic [WIDTH:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign s0[i]        = fa_sum(a[i], b[i], carry[i]);
    assign carry[i + 1] = fa_carry(a[i], b[i], carry[i]);
  end

  assign cout0 = carry[WIDTH];
endmodule

// File: rtl/ones_prefix.sv
module ones_prefix #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] s0,
  output logic [WIDTH-1:0] pfx,
  output logic             all_ones
);
  logic [WIDTH:0] run;
  assign run[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_run
    assign run[i + 1] = run[i] & s0[i];
  end

  assign pfx      = run[WIDTH-1:0];
  assign all_ones = run[WIDTH];
endmodule

// File: rtl/cond_invert.sv
module cond_invert #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] s0,
  input  logic [WIDTH-1:0] pfx,
  input  logic             all_ones,
  input  logic             cout0,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH-1:0] sel;

  for (genvar i = 0; i < WIDTH; i++) begin : g_mux
    assign sel[i] = cin & pfx[i];
    assign sum[i] = sel[i] ? ~s0[i] : s0[i];
  end

  assign cout = cin ? (cout0 | all_ones) : cout0;

  always_comb begin
    if (!$isunknown({s0, pfx, all_ones, cout0, cin})) begin
      // R3
      cin0_pass_chk: assert (cin || (sum == s0 && cout == cout0))
        else $error("zero carry-in altered the ripple result");
      // R5
      wrap_chk: assert (!(cin && all_ones) || (sum == '0 && cout))
        else $error("all-ones increment did not wrap");
      // R2
      excl_chk: assert (!(all_ones && cout0))
        else $error("all-ones sum together with ripple carry");
    end
  end
endmodule

// File: rtl/addone_csel_group.sv
module addone_csel_group #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int          TOTAL = WIDTH + 1;
  localparam logic [WIDTH-1:0] ONES = '1;

  logic [WIDTH-1:0] s0, pfx, sum_c;
  logic             cout0, all_ones, cout_c;
  logic             past_ok;

  rca_cin0 #(.WIDTH(WIDTH)) u_rca (
    .a(a_i), .b(b_i), .s0(s0), .cout0(cout0)
  );

  ones_prefix #(.WIDTH(WIDTH)) u_pfx (
    .s0(s0), .pfx(pfx), .all_ones(all_ones)
  );

  cond_invert #(.WIDTH(WIDTH)) u_inv (
    .s0(s0), .pfx(pfx), .all_ones(all_ones), .cout0(cout0), .cin(cin_i),
    .sum(sum_c), .cout(cout_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o   <= '0;
      cout_o  <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      sum_o   <= sum_c;
      cout_o  <= cout_c;
      past_ok <= 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum_o == '0 && !cout_o));

  // R2
  arith_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ({cout_o, sum_o} ==
      TOTAL'({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + TOTAL'($past(cin_i)))));

  // R6
  ones_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(cin_i) && WIDTH'($past(a_i) + $past(b_i)) == ONES)
      |-> (sum_o == ONES && !cout_o));
endmodule

// File: tb/sim_addone_csel_group.sv
module sim_addone_csel_group;
  localparam int W0 = 6;
  localparam int W1 = 1;
  localparam int W2 = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W0-1:0] a0 = '0, b0 = '0, s0o;
  logic [W1-1:0] a1 = '0, b1 = '0, s1o;
  logic [W2-1:0] a2 = '0, b2 = '0, s2o;
  logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0;
  logic co0, co1, co2;

  addone_csel_group #(.WIDTH(W0)) u0 (.clk(clk), .rst(rst), .a_i(a0), .b_i(b0),
    .cin_i(c0), .sum_o(s0o), .cout_o(co0));
  addone_csel_group #(.WIDTH(W1)) u1 (.clk(clk), .rst(rst), .a_i(a1), .b_i(b1),
    .cin_i(c1), .sum_o(s1o), .cout_o(co1));
  addone_csel_group #(.WIDTH(W2)) u2 (.clk(clk), .rst(rst), .a_i(a2), .b_i(b2),
    .cin_i(c2), .sum_o(s2o), .cout_o(co2));

  typedef struct { logic [W2:0] exp; int req; int dut; } item_t;
  item_t q[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Tag: R3 cin 0, R6 cin 0 all ones, R5 cin 1 all ones, R7 top-bit flip, R4 otherwise
  function automatic int classify(int w, logic [W2:0] a, logic [W2:0] b, logic c);
    logic [W2:0] mask, s0;
    mask = (17'd1 << w) - 17'd1;
    s0   = (a + b) & mask;
    if (!c) return (s0 == mask) ? 6 : 3;
    if (s0 == mask) return 5;
    if (s0 == (mask >> 1)) return 7;
    return 4;
  endfunction

  task automatic push(int dut, int w, logic [W2:0] a, logic [W2:0] b, logic c);
    item_t it;
    it.exp = a + b + {16'd0, c};
    it.req = (dut == 0) ? classify(w, a, b, c) : 8; // R8 for widths 1 and 16
    it.dut = dut;
    q.push_back(it);
  endtask

  task automatic drive0(logic [W0-1:0] a, logic [W0-1:0] b, logic c);
    @(negedge clk);
    a0 = a; b0 = b; c0 = c;
    push(0, W0, {11'd0, a}, {11'd0, b}, c);
  endtask

  task automatic drive1(logic [W1-1:0] a, logic [W1-1:0] b, logic c);
    @(negedge clk);
    a1 = a; b1 = b; c1 = c;
    push(1, W1, {16'd0, a}, {16'd0, b}, c);
  endtask

  task automatic drive2(logic [W2-1:0] a, logic [W2-1:0] b, logic c);
    @(negedge clk);
    a2 = a; b2 = b; c2 = c;
    push(2, W2, {1'b0, a}, {1'b0, b}, c);
  endtask

  // Monitor: R2 one-cycle latency, sampled 1 ns after the capturing edge
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      item_t it;
      logic [W2:0] act;
      it = q.pop_front();
      case (it.dut)
        0: act = {10'd0, co0, s0o};
        1: act = {15'd0, co1, s1o};
        default: act = {co2, s2o};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL R%0d (R2 latency) dut %0d actual %h expected %h",
                 it.req, it.dut, act, it.exp);
      end
    end
  end

  task automatic check_reset(string tag);
    checks++;
    if (s0o !== '0 || co0 !== 1'b0 || s1o !== '0 || co1 !== 1'b0 ||
        s2o !== '0 || co2 !== 1'b0) begin
      errors++;
      $display("FAIL %s actual %h/%h/%h expected 0", tag,
               {co0, s0o}, {co1, s1o}, {co2, s2o});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check_reset("R1 initial reset");
    @(negedge clk);
    rst = 1'b0;

    // R3 R4 R5 R6 R7: exhaustive 6-bit operands and carry-in
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++)
        for (int c = 0; c < 2; c++)
          drive0(W0'(a), W0'(b), c[0]);

    // R8: width 1, exhaustive
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 2; c++)
          drive1(a[0], b[0], c[0]);

    // R8 with R5 R6 R7 at width 16: directed all-ones and top-bit cases
    drive2(16'hFFFF, 16'h0000, 1'b1);
    drive2(16'hFFFF, 16'h0000, 1'b0);
    drive2(16'h5555, 16'hAAAA, 1'b1);
    drive2(16'h7FFF, 16'h0000, 1'b1);
    drive2(16'h3FFF, 16'h4000, 1'b1);
    drive2(16'hFFFF, 16'hFFFF, 1'b1);
    drive2(16'h8000, 16'h8000, 1'b0);
    for (int i = 0; i < 3000; i++)
      drive2(W2'($urandom), W2'($urandom), 1'($urandom));

    repeat (3) @(negedge clk);
    rst = 1'b1;
    drive0(6'h3F, 6'h3F, 1'b1);
    q.delete();
    @(posedge clk);
    #1 check_reset("R1 mid-run reset");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end
endmodule